// File: doc/BRIEF.md
# SPI Serial Memory Slave Command Engine

This block is the serial front end of a byte-addressed SPI memory slave. It oversamples the chip select, serial clock, serial input and an active-low suspend input with a fast system clock. From these it assembles an 8-bit command, decodes it into one of six operations, and then either streams data out or hands received bytes to a separate program controller. Array reads are served from a synchronous RAM read port with one cycle of latency. Status reads return the protection level, the write-enable flag and the busy flag, which the program controller supplies.

Bits are sampled on rising serial clock edges and output bits change after falling edges. This holds whether the clock idles low or high between transfers. Write-type commands never touch the array from here. Each completed data byte is offered to the program controller as a single-cycle valid pulse together with its target address. A start pulse follows when chip select is released. Write-enable set and clear commands produce their own single-cycle pulses. The suspend input lets the master freeze a transfer part-way through and later resume it.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: Command codes (first byte, most significant bit first) are 0x06 enable writes, 0x04 disable writes, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array. Any other code is invalid and causes no pulse at the program-controller outputs.
- R2: SI is sampled on each SCK rising edge, starting with the first rise after chip select falls. SO and its enable change only after SCK falling edges. This works both when SCK idles low and when it idles high.
- R3: Read array takes a high and a low address byte. Only the low 11 address bits are used and the upper 5 are ignored. The byte at that address is then shifted out MSB first, followed by bytes at consecutive addresses.
- R4: During a read, the address after 0x7FF is 0x000.
- R5: The SO enable is 0 while command, address or write data bits are received. SI is ignored while data is being shifted out.
- R6: After an invalid command the slave takes no further bits, issues no memory read and keeps the SO enable 0 until the next chip-select fall. The next transfer then works normally.
- R7: Read status returns {4'b0000, bp[1], bp[0], wen, busy}. This byte is repeated for as long as clocks continue.
- R8: While busy is 1, only read status is accepted, and its bit 0 reads 1. Any other command is treated as invalid.
- R9: Enable writes and disable writes each give exactly one pulse on their own output once the command byte completes.
- R10: After write array and its address, each data byte gives one byte-valid pulse with kind 0. The pulse carries the data and the address. Within a 16-byte page, the low 4 address bits advance by one per byte and wrap to 0 while the upper bits stay fixed. One start pulse follows the rise of chip select.
- R11: Write status gives one byte-valid pulse with kind 1 and the received byte. One start pulse follows the rise of chip select.
- R12: The suspend input is taken or released only while SCK is low. While suspended, SCK and SI are ignored and the transfer resumes where it stopped. If suspend is asserted and released while SCK stays high, it has no effect on the sequence.
- R13: Suspend low forces the SO enable to 0 at once, with no clock edge needed.
- R14: After reset the SO enable, the memory read strobe and all program-controller pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Suspend, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO (0 = high impedance) |
| mem_addr_o | output | AW | RAM read address |
| mem_rd_o | output | 1 | RAM read strobe |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after the strobe |
| st_bp_i | input | 2 | Block protection level from program controller |
| st_wen_i | input | 1 | Write-enable flag from program controller |
| st_busy_i | input | 1 | Programming-in-progress flag |
| pc_wren_o | output | 1 | Pulse: enable-writes command received |
| pc_wrdi_o | output | 1 | Pulse: disable-writes command received |
| pc_byte_valid_o | output | 1 | Pulse: one write data byte is ready |
| pc_byte_o | output | 8 | Write data byte |
| pc_addr_o | output | AW | Array address for the byte |
| pc_kind_o | output | 1 | 0 = array write, 1 = status write |
| pc_start_o | output | 1 | Pulse: chip select released after write data |

## Verification
The bench builds the block with its defaults: 2048 bytes, 16-byte pages and two synchronizer stages. This makes the wrap from 0x7FF to 0x000 and the page wrap from offset 15 to 0 reachable with a few bytes each. The serial clock half-period is eight system clocks. That leaves room for the synchronizer delay and the memory prefetch between edges, so each SO bit is sampled just before the rising edge that follows its falling edge.

// File: rtl/sem_pkg.sv
`timescale 1ns/1ps
package sem_pkg;

  typedef enum logic [2:0] {
    P_OPC,
    P_AH,
    P_AL,
    P_WD,
    P_OUT,
    P_MUTE
  } phase_t;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRITE = 8'h02;

endpackage

// File: rtl/sem_sync.sv
`timescale 1ns/1ps
module sem_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_bit,
  output logic held
);

  // bundle order: {cs_n, sck, si, hold_n}
  localparam logic [3:0] IDLE_V = 4'b1001;

  logic [3:0] ff [SYNC];
  logic [3:0] s;
  logic       sck_d;
  logic       csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC; i++) ff[i] <= IDLE_V;
    end else begin
      ff[0] <= {cs_n_i, sck_i, si_i, hold_n_i};
      for (int i = 1; i < SYNC; i++) ff[i] <= ff[i-1];
    end
  end

  assign s = ff[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
      held  <= 1'b0;
    end else begin
      sck_d <= s[2];
      csn_d <= s[3];
      if (s[3])
        held <= 1'b0;
      else if (!s[2])
        held <= !s[0];
    end
  end

  assign cs_act   = !s[3];
  assign cs_rise  = s[3] && !csn_d;
  assign sck_rise = cs_act && !held && s[2] && !sck_d;
  assign sck_fall = cs_act && !held && !s[2] && sck_d;
  assign si_bit   = s[1];

endmodule

// File: rtl/sem_decoder.sv
`timescale 1ns/1ps
module sem_decoder
  import sem_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          si_bit,
  input  logic          busy_i,
  output logic          go_mem,
  output logic          go_stat,
  output logic [AW-1:0] start_addr,
  output logic          pc_wren,
  output logic          pc_wrdi,
  output logic          pc_byte_valid,
  output logic [7:0]    pc_byte,
  output logic [AW-1:0] pc_addr,
  output logic          pc_kind,
  output logic          pc_start,
  output phase_t        phase,
  output logic [2:0]    bcnt
);

  logic [6:0]    sh;
  logic [7:0]    sh_n;
  logic [AW-9:0] a_hi;
  logic          rd_cmd;
  logic          got_byte;
  logic [AW-1:0] wr_addr;

  assign sh_n = {sh, si_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= P_OPC;
      bcnt          <= '0;
      sh            <= '0;
      a_hi          <= '0;
      rd_cmd        <= 1'b0;
      got_byte      <= 1'b0;
      wr_addr       <= '0;
      start_addr    <= '0;
      go_mem        <= 1'b0;
      go_stat       <= 1'b0;
      pc_wren       <= 1'b0;
      pc_wrdi       <= 1'b0;
      pc_byte_valid <= 1'b0;
      pc_byte       <= '0;
      pc_addr       <= '0;
      pc_kind       <= 1'b0;
      pc_start      <= 1'b0;
    end else begin
      go_mem        <= 1'b0;
      go_stat       <= 1'b0;
      pc_wren       <= 1'b0;
      pc_wrdi       <= 1'b0;
      pc_byte_valid <= 1'b0;
      pc_start      <= 1'b0;
      if (cs_rise && phase == P_WD && got_byte)
        pc_start <= 1'b1;
      if (!cs_act) begin
        phase    <= P_OPC;
        bcnt     <= '0;
        got_byte <= 1'b0;
      end else if (sck_rise && phase != P_OUT && phase != P_MUTE) begin
        sh   <= sh_n[6:0];
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          case (phase)
            P_OPC: begin
              if (busy_i && sh_n != CMD_RDSR) begin
                phase <= P_MUTE;
              end else begin
                case (sh_n)
                  CMD_READ:  begin rd_cmd <= 1'b1; phase <= P_AH; end
                  CMD_WRITE: begin rd_cmd <= 1'b0; pc_kind <= 1'b0; phase <= P_AH; end
                  CMD_WRSR:  begin pc_kind <= 1'b1; phase <= P_WD; end
                  CMD_RDSR:  begin go_stat <= 1'b1; phase <= P_OUT; end
                  CMD_WREN:  begin pc_wren <= 1'b1; phase <= P_MUTE; end
                  CMD_WRDI:  begin pc_wrdi <= 1'b1; phase <= P_MUTE; end
                  default:   phase <= P_MUTE;
                endcase
              end
            end
            P_AH: begin
              a_hi  <= sh_n[AW-9:0];
              phase <= P_AL;
            end
            P_AL: begin
              if (rd_cmd) begin
                start_addr <= {a_hi, sh_n};
                go_mem     <= 1'b1;
                phase      <= P_OUT;
              end else begin
                wr_addr <= {a_hi, sh_n};
                phase   <= P_WD;
              end
            end
            P_WD: begin
              pc_byte_valid       <= 1'b1;
              pc_byte             <= sh_n;
              pc_addr             <= wr_addr;
              wr_addr[PW-1:0]     <= wr_addr[PW-1:0] + 1'b1;
              got_byte            <= 1'b1;
            end
            default: phase <= phase;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sem_shifter.sv
`timescale 1ns/1ps
module sem_shifter #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sck_fall,
  input  logic          go_mem,
  input  logic          go_stat,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    st_bp,
  input  logic          st_wen,
  input  logic          st_busy,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          so_r,
  output logic          oe_r
);

  logic       act;
  logic       src_stat;
  logic       ld_q;
  logic [2:0] obit;
  logic [7:0] obyte;
  logic [7:0] status;

  assign status = {4'b0000, st_bp, st_wen, st_busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      src_stat <= 1'b0;
      ld_q     <= 1'b0;
      obit     <= 3'd7;
      obyte    <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      so_r     <= 1'b0;
      oe_r     <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      ld_q   <= mem_rd;
      if (ld_q)
        obyte <= mem_rdata;
      if (!cs_act) begin
        act  <= 1'b0;
        oe_r <= 1'b0;
      end else begin
        if (go_mem) begin
          act      <= 1'b1;
          src_stat <= 1'b0;
          mem_addr <= start_addr;
          mem_rd   <= 1'b1;
          obit     <= 3'd7;
        end
        if (go_stat) begin
          act      <= 1'b1;
          src_stat <= 1'b1;
          obyte    <= status;
          obit     <= 3'd7;
        end
        if (sck_fall && act) begin
          so_r <= obyte[obit];
          oe_r <= 1'b1;
          obit <= obit - 3'd1;
          if (obit == 3'd0) begin
            if (src_stat) begin
              obyte <= status;
            end else begin
              mem_addr <= mem_addr + 1'b1;
              mem_rd   <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_cmd_engine.sv
`timescale 1ns/1ps
module spi_mem_cmd_engine #(
  parameter int DEPTH = 2048,
  parameter int PAGE  = 16,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_i,
  input  logic          sck_i,
  input  logic          si_i,
  input  logic          hold_n_i,
  output logic          so_o,
  output logic          so_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic [1:0]    st_bp_i,
  input  logic          st_wen_i,
  input  logic          st_busy_i,
  output logic          pc_wren_o,
  output logic          pc_wrdi_o,
  output logic          pc_byte_valid_o,
  output logic [7:0]    pc_byte_o,
  output logic [AW-1:0] pc_addr_o,
  output logic          pc_kind_o,
  output logic          pc_start_o
);

  logic              cs_act, cs_rise, sck_rise, sck_fall, si_bit, held;
  logic              go_mem, go_stat;
  logic [AW-1:0]     start_addr;
  sem_pkg::phase_t   phase;
  logic [2:0]        bcnt;
  logic              so_r, oe_r;

  sem_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .cs_n_i(cs_n_i), .sck_i(sck_i), .si_i(si_i),
    .hold_n_i(hold_n_i), .cs_act(cs_act), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_bit), .held(held)
  );

  sem_decoder #(.AW(AW), .PW(PW)) u_dec (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .si_bit(si_bit), .busy_i(st_busy_i),
    .go_mem(go_mem), .go_stat(go_stat), .start_addr(start_addr),
    .pc_wren(pc_wren_o), .pc_wrdi(pc_wrdi_o),
    .pc_byte_valid(pc_byte_valid_o), .pc_byte(pc_byte_o),
    .pc_addr(pc_addr_o), .pc_kind(pc_kind_o), .pc_start(pc_start_o),
    .phase(phase), .bcnt(bcnt)
  );

  sem_shifter #(.AW(AW)) u_shf (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall),
    .go_mem(go_mem), .go_stat(go_stat), .start_addr(start_addr),
    .st_bp(st_bp_i), .st_wen(st_wen_i), .st_busy(st_busy_i),
    .mem_rdata(mem_rdata_i), .mem_addr(mem_addr_o), .mem_rd(mem_rd_o),
    .so_r(so_r), .oe_r(oe_r)
  );

  assign so_o    = so_r;
  assign so_oe_o = oe_r && !held && hold_n_i;

endmodule

// File: rtl/sem_chk.sv
`timescale 1ns/1ps
module sem_chk
  import sem_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_act,
  input logic       sck_fall,
  input logic       held,
  input phase_t     phase,
  input logic [2:0] bcnt,
  input logic       oe_r,
  input logic       mem_rd,
  input logic       byte_valid
);

  // R5
  input_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_act && (phase == P_OPC || phase == P_AH || phase == P_AL || phase == P_WD)) |-> !oe_r);

  // R12
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_act && held) |=> $stable(bcnt));

  // R2
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_r) |-> $past(sck_fall));

  // R3
  read_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> $past(cs_act));

  // R10
  handoff_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> !oe_r);

  // R6
  mute_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == P_MUTE) |-> (!oe_r && !mem_rd));

endmodule

bind spi_mem_cmd_engine sem_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall), .held(held),
  .phase(phase), .bcnt(bcnt), .oe_r(oe_r), .mem_rd(mem_rd_o),
  .byte_valid(pc_byte_valid_o)
);

// File: tb/sim_spi_mem_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_mem_cmd_engine;

  localparam int H  = 8;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [1:0] bp = 2'b00;
  logic wen = 1'b0, busy = 1'b0;
  logic so, so_oe, mem_rd, wren, wrdi, bvalid, kind, start;
  logic [AW-1:0] mem_addr, pc_addr;
  logic [7:0] mem_rdata = 8'h00, pc_byte;

  int nchk = 0, nfail = 0;
  int bv_cnt = 0, rd_cnt = 0, oe_cnt = 0, wren_cnt = 0, wrdi_cnt = 0, st_cnt = 0;
  logic [7:0]    bv_byte [16];
  logic [AW-1:0] bv_addr [16];
  logic          bv_kind [16];

  always #2.5 clk = ~clk;

  spi_mem_cmd_engine u0 (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
    .so_o(so), .so_oe_o(so_oe), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_rdata_i(mem_rdata), .st_bp_i(bp), .st_wen_i(wen), .st_busy_i(busy),
    .pc_wren_o(wren), .pc_wrdi_o(wrdi), .pc_byte_valid_o(bvalid), .pc_byte_o(pc_byte),
    .pc_addr_o(pc_addr), .pc_kind_o(kind), .pc_start_o(start)
  );

  function automatic logic [7:0] mval(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], 5'b10110};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mval(mem_addr);
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (so_oe) oe_cnt <= oe_cnt + 1;
    if (wren) wren_cnt <= wren_cnt + 1;
    if (wrdi) wrdi_cnt <= wrdi_cnt + 1;
    if (start) st_cnt <= st_cnt + 1;
    if (bvalid) begin
      bv_byte[bv_cnt[3:0]] <= pc_byte;
      bv_addr[bv_cnt[3:0]] <= pc_addr;
      bv_kind[bv_cnt[3:0]] <= kind;
      bv_cnt <= bv_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    sck = m3;
    waitn(H);
    cs_n = 1'b0;
    waitn(H);
  endtask

  task automatic desel(input bit m3);
    if (!m3) sck = 1'b0;
    waitn(H);
    cs_n = 1'b1;
    sck = m3;
    waitn(3 * H);
  endtask

  task automatic xbit(input logic b, output logic o, output logic oe);
    sck = 1'b0;
    si  = b;
    waitn(H);
    o  = so;
    oe = so_oe;
    sck = 1'b1;
    waitn(H);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r, output logic [7:0] oev);
    for (int i = 7; i >= 0; i--) xbit(b[i], r[i], oev[i]);
  endtask

  task automatic t_reset;
    chk(so_oe == 1'b0, "R14 oe", so_oe, 0);
    chk(mem_rd == 1'b0, "R14 mem_rd", mem_rd, 0);
    chk({wren, wrdi, bvalid, start} == 4'b0, "R14 pulses", {wren, wrdi, bvalid, start}, 0);
  endtask

  task automatic t_read(input bit m3, input logic [15:0] a, input int n, input string req);
    logic [7:0] r, oev;
    logic [AW-1:0] ea;
    sel(m3);
    xbyte(8'h03, r, oev);
    chk(oev == 8'h00, "R5 oe during opcode", oev, 0);
    xbyte(a[15:8], r, oev);
    xbyte(a[7:0], r, oev);
    chk(oev == 8'h00, "R5 oe during address", oev, 0);
    ea = a[AW-1:0];
    for (int k = 0; k < n; k++) begin
      xbyte(8'hA5 ^ k[7:0], r, oev);
      chk(r == mval(ea), req, r, mval(ea));
      chk(oev == 8'hFF, "R5 oe during output", oev, 8'hFF);
      ea = ea + 1'b1;
    end
    desel(m3);
  endtask

  task automatic t_rdsr;
    logic [7:0] r, oev;
    bp = 2'b10; wen = 1'b1; busy = 1'b0;
    sel(0);
    xbyte(8'h05, r, oev);
    xbyte(8'h00, r, oev);
    chk(r == 8'h0A, "R7 status byte", r, 8'h0A);
    xbyte(8'hFF, r, oev);
    chk(r == 8'h0A, "R7 status repeat", r, 8'h0A);
    desel(0);
    bp = 2'b00; wen = 1'b0; busy = 1'b1;
    sel(0);
    xbyte(8'h05, r, oev);
    xbyte(8'h00, r, oev);
    chk(r[0] == 1'b1, "R8 busy bit in status", r[0], 1);
    desel(0);
  endtask

  task automatic t_busy_block;
    logic [7:0] r, oev;
    int rd0, oe0, w0;
    busy = 1'b1;
    rd0 = rd_cnt; oe0 = oe_cnt; w0 = wren_cnt;
    sel(0);
    xbyte(8'h03, r, oev);
    xbyte(8'h00, r, oev);
    xbyte(8'h10, r, oev);
    xbyte(8'h00, r, oev);
    desel(0);
    sel(0);
    xbyte(8'h06, r, oev);
    desel(0);
    chk(rd_cnt == rd0, "R8 no memory read while busy", rd_cnt - rd0, 0);
    chk(oe_cnt == oe0, "R8 SO quiet while busy", oe_cnt - oe0, 0);
    chk(wren_cnt == w0, "R8 no enable pulse while busy", wren_cnt - w0, 0);
    busy = 1'b0;
  endtask

  task automatic t_invalid;
    logic [7:0] r, oev;
    int rd0, oe0, w0, d0, b0;
    rd0 = rd_cnt; oe0 = oe_cnt; w0 = wren_cnt; d0 = wrdi_cnt; b0 = bv_cnt;
    sel(0);
    xbyte(8'h07, r, oev);
    xbyte(8'h03, r, oev);
    xbyte(8'h00, r, oev);
    xbyte(8'h20, r, oev);
    xbyte(8'h00, r, oev);
    desel(0);
    chk(rd_cnt == rd0, "R6 no memory read after invalid", rd_cnt - rd0, 0);
    chk(oe_cnt == oe0, "R6 SO quiet after invalid", oe_cnt - oe0, 0);
    chk(wren_cnt + wrdi_cnt + bv_cnt == w0 + d0 + b0, "R1 no pulse for invalid code",
        wren_cnt + wrdi_cnt + bv_cnt - w0 - d0 - b0, 0);
    t_read(0, 16'h0240, 1, "R6 recovery read");
  endtask

  task automatic t_enables;
    logic [7:0] r, oev;
    int w0, d0;
    w0 = wren_cnt; d0 = wrdi_cnt;
    sel(0); xbyte(8'h06, r, oev); desel(0);
    chk(wren_cnt == w0 + 1, "R9 enable pulse", wren_cnt - w0, 1);
    chk(wrdi_cnt == d0, "R9 no disable pulse", wrdi_cnt - d0, 0);
    sel(1); xbyte(8'h04, r, oev); desel(1);
    chk(wrdi_cnt == d0 + 1, "R9 disable pulse", wrdi_cnt - d0, 1);
    chk(wren_cnt == w0 + 1, "R9 single enable pulse", wren_cnt - w0, 1);
  endtask

  task automatic t_write;
    logic [7:0] r, oev;
    logic [7:0] dat [3];
    logic [AW-1:0] ea [3];
    int b0, s0, idx;
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
    ea[0] = 11'h1FE; ea[1] = 11'h1FF; ea[2] = 11'h1F0;
    b0 = bv_cnt; s0 = st_cnt;
    sel(0);
    xbyte(8'h02, r, oev);
    xbyte(8'h01, r, oev);
    xbyte(8'hFE, r, oev);
    for (int k = 0; k < 3; k++) begin
      xbyte(dat[k], r, oev);
      chk(oev == 8'h00, "R5 oe during write data", oev, 0);
    end
    desel(0);
    chk(bv_cnt == b0 + 3, "R10 byte pulses", bv_cnt - b0, 3);
    for (int k = 0; k < 3; k++) begin
      idx = (b0 + k) % 16;
      chk(bv_addr[idx] == ea[k], "R10 page address", bv_addr[idx], ea[k]);
      chk(bv_byte[idx] == dat[k], "R10 data byte", bv_byte[idx], dat[k]);
      chk(bv_kind[idx] == 1'b0, "R10 kind", bv_kind[idx], 0);
    end
    chk(st_cnt == s0 + 1, "R10 start pulse", st_cnt - s0, 1);
  endtask

  task automatic t_wrsr;
    logic [7:0] r, oev;
    int b0, s0, idx;
    b0 = bv_cnt; s0 = st_cnt;
    sel(1);
    xbyte(8'h01, r, oev);
    xbyte(8'h0C, r, oev);
    desel(1);
    idx = b0 % 16;
    chk(bv_cnt == b0 + 1, "R11 byte pulse", bv_cnt - b0, 1);
    chk(bv_byte[idx] == 8'h0C, "R11 data", bv_byte[idx], 8'h0C);
    chk(bv_kind[idx] == 1'b1, "R11 kind", bv_kind[idx], 1);
    chk(st_cnt == s0 + 1, "R11 start pulse", st_cnt - s0, 1);
  endtask

  task automatic t_hold;
    logic [7:0] r, oev;
    logic o, e;
    logic [7:0] lo;
    lo = 8'h23;
    sel(0);
    xbyte(8'h03, r, oev);
    xbyte(8'hC1, r, oev);
    for (int i = 7; i >= 5; i--) xbit(lo[i], o, e);
    sck = 1'b0;
    waitn(H);
    hold_n = 1'b0;
    waitn(H);
    for (int k = 0; k < 5; k++) begin
      si = k[0];
      sck = 1'b1; waitn(H);
      sck = 1'b0; waitn(H);
    end
    chk(so_oe == 1'b0, "R12 SO off while held", so_oe, 0);
    hold_n = 1'b1;
    waitn(H);
    for (int i = 4; i >= 0; i--) xbit(lo[i], o, e);
    xbyte(8'h00, r, oev);
    chk(r == mval(11'h123), "R12 resume after hold", r, mval(11'h123));
    hold_n = 1'b0;
    #1;
    chk(so_oe == 1'b0, "R13 immediate SO off", so_oe, 0);
    waitn(H);
    hold_n = 1'b1;
    #1;
    chk(so_oe == 1'b1, "R12 hold during SCK high not taken", so_oe, 1);
    waitn(H);
    xbyte(8'h00, r, oev);
    chk(r == mval(11'h124), "R12 sequence intact", r, mval(11'h124));
    desel(0);
  endtask

  initial begin
    waitn(5);
    rst = 1'b0;
    waitn(2);
    t_reset();
    t_read(0, 16'hF812, 3, "R3 read data upper bits ignored");
    t_read(0, 16'h07FE, 3, "R4 read wrap");
    t_read(1, 16'h0345, 2, "R2 idle-high clock read");
    t_rdsr();
    t_busy_block();
    t_invalid();
    t_enables();
    t_write();
    t_wrsr();
    t_hold();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
    $finish;
  end

endmodule